// File: doc/BRIEF.md
# Banked Shared Scratchpad with Conflict Replay

This block is a word-addressed on-chip scratchpad shared by a group of 32 lanes that issue one vector load or store together. Each lane supplies a byte address, a valid bit, a write enable and a 32-bit write value. The storage is split into `BANKS` independent banks, and each bank can read or write one 32-bit word per clock. A lane's bank is taken from the low bits of its word address, and its row inside that bank comes from the bits above them.

When active lanes fall in distinct banks, the whole vector access is serviced in one cycle. When several lanes land in the same bank, the block replays the access. In each replay cycle every bank serves the lowest-numbered lane still waiting on it. A bank with k waiting lanes therefore needs k cycles, and the request lasts as long as its busiest bank. Lanes that read the same word are not merged. Read results are captured into one register per lane and are presented when `done` pulses.

A small sequencer has three states. IDLE (`ready` high) moves to SERVE when a request with at least one valid lane is accepted, or straight to DONE when the request has no valid lane. SERVE stays in SERVE while lanes remain pending after the current cycle's grants, and moves to DONE on the cycle that serves the last pending lane. DONE (`done` high for one cycle) always returns to IDLE.

Top module: `shared_scratch_banked`

## Requirements
- R1: A lane's word address is its byte address shifted right by 2. Its bank is the word address modulo `BANKS`, and its row within that bank is (word address / `BANKS`) modulo `ROWS`. A value written to a byte address is read back from that same address. Each bank serves at most one lane per cycle.
- R2: A request whose valid lanes all map to distinct banks spends one cycle in SERVE. `done` is high in the 2nd cycle after the accepting clock edge.
- R3: If the most heavily loaded bank has k valid lanes, the request spends exactly k cycles in SERVE. `done` is high in cycle k+1 after the accepting edge.
- R4: With 32 valid lanes on one bank, the request takes 32 service cycles.
- R5: Within a bank, pending lanes are served in increasing lane order, and the lowest pending lane is served in every SERVE cycle. When several lanes write the same word, the highest-numbered writer's value remains.
- R6: Lanes reading the same word are served one per cycle, with no broadcast merging, and all of them receive that word.
- R7: `ready` is high only in IDLE. It is low from the accepting edge until the `done` cycle, and a `req_valid` presented while `ready` is low has no effect on memory or on results.
- R8: `done` is a one-cycle pulse. From `done` until the next acceptance, `lane_rdata` holds each reading lane's word. Lanes that were invalid or wrote return zero.
- R9: With 32 banks, a lane word stride of 32 puts all lanes in one bank (32 cycles), and a stride of 33 spreads them over all banks (1 cycle). With 16 banks, a stride of 33 gives 2 cycles.
- R10: A request with no valid lane goes straight to DONE. `done` is high in the 1st cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Vector request present; taken when `ready` is high |
| ready | output | 1 | Sequencer idle and able to accept |
| lane_valid | input | LANES | Per-lane active flag |
| lane_wen | input | LANES | Per-lane write enable (1 = store, 0 = load) |
| lane_addr | input | LANES*ADDR_W | Per-lane byte address; lane l at bits [l*ADDR_W +: ADDR_W] |
| lane_wdata | input | LANES*32 | Per-lane store data; lane l at bits [l*32 +: 32] |
| done | output | 1 | One-cycle completion pulse |
| lane_rdata | output | LANES*32 | Per-lane gathered load data; lane l at bits [l*32 +: 32] |

## Verification
A stuck or mis-cleared pending bit shows at the ports as a `done` that arrives late, early or never, so the exact latency of every request is compared with the busiest-bank count, cycle for cycle. A wrong bank or row decode, or a grant given to the wrong lane, shows up as wrong `lane_rdata` on the `done` of the first later load that touches the affected word. The bench keeps a flat word model in which operations are applied in lane order, and checks both a 32-bank and a 16-bank instance against it. The replay order is visible at the ports through the surviving value after same-word writes.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SERVE,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/scratch_pick.sv
// Lowest-index selector: grants the first candidate lane of one bank.
module scratch_pick #(
    parameter int LANES = 32,
    parameter int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] cand,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic [LANES-1:0] onehot
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (cand[l]) begin
                hit = 1'b1;
                idx = IDX_W'(l);
            end
        end
        onehot = hit ? (LANES'(1) << idx) : '0;
    end
endmodule

// File: rtl/scratch_bank.sv
// One bank: single port, one word per cycle, combinational read.
module scratch_bank
    import scratch_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[row] <= wdata;
        end
    end

    assign rdata = mem[row];
endmodule

// File: rtl/scratch_seq.sv
// Replay sequencer: IDLE -> SERVE (repeat) -> DONE -> IDLE.
module scratch_seq
    import scratch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic any_lane,
    input  logic last_round,
    output logic ready,
    output logic serving,
    output logic done,
    output logic load
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = any_lane ? ST_SERVE : ST_DONE;
                end
            end
            ST_SERVE: begin
                if (last_round) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready   = 1'b0;
        serving = 1'b0;
        done    = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                load  = req_valid;
            end
            ST_SERVE: serving = 1'b1;
            ST_DONE:  done    = 1'b1;
            default: ;
        endcase
    end

    // R7: acceptance drops ready on the next cycle
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);

    // R8: done lasts exactly one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the cycle after done is idle again
    p_done_then_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
endmodule

// File: rtl/shared_scratch_banked.sv
module shared_scratch_banked
    import scratch_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ROWS   = 16,
    parameter int ADDR_W = 2 + $clog2(BANKS) + $clog2(ROWS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    ready,
    input  logic [LANES-1:0]        lane_valid,
    input  logic [LANES-1:0]        lane_wen,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [LANES*WORD_W-1:0] lane_wdata,
    output logic                    done,
    output logic [LANES*WORD_W-1:0] lane_rdata
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int LANE_W = $clog2(LANES);

    logic [ADDR_W-1:0] addr_q    [LANES];
    logic [WORD_W-1:0] wdata_q   [LANES];
    logic [WORD_W-1:0] rdata_q   [LANES];
    logic [BANK_W-1:0] lane_bank [LANES];
    logic [ROW_W-1:0]  lane_row  [LANES];
    logic [LANES-1:0]  wen_q;
    logic [LANES-1:0]  pending;
    logic [LANES-1:0]  grant;
    logic [LANES-1:0]  pick_oh   [BANKS];
    logic [WORD_W-1:0] bank_rd   [BANKS];

    logic serving, load, last_round;

    // Bank / row decode per lane
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_bank[l] = addr_q[l][2 +: BANK_W];
            lane_row[l]  = addr_q[l][2 + BANK_W +: ROW_W];
        end
    end

    // Per-bank selection and storage
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [LANES-1:0]  hit_map;
        logic [LANES-1:0]  cand;
        logic              hit;
        logic [LANE_W-1:0] idx;

        always_comb begin
            for (int l = 0; l < LANES; l++) begin
                hit_map[l] = (lane_bank[l] == BANK_W'(b));
            end
        end

        assign cand = pending & hit_map & {LANES{serving}};

        scratch_pick #(.LANES(LANES), .IDX_W(LANE_W)) u_pick (
            .cand   (cand),
            .hit    (hit),
            .idx    (idx),
            .onehot (pick_oh[b])
        );

        scratch_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_mem (
            .clk   (clk),
            .we    (hit && wen_q[idx]),
            .row   (lane_row[idx]),
            .wdata (wdata_q[idx]),
            .rdata (bank_rd[b])
        );

        // R1: one lane at most per bank per cycle
        p_one_grant_per_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant & hit_map));
    end

    always_comb begin
        grant = '0;
        for (int b = 0; b < BANKS; b++) begin
            grant = grant | pick_oh[b];
        end
    end

    assign last_round = ((pending & ~grant) == '0);

    scratch_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .any_lane   (|lane_valid),
        .last_round (last_round),
        .ready      (ready),
        .serving    (serving),
        .done       (done),
        .load       (load)
    );

    // Request capture and pending mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            wen_q   <= '0;
            for (int l = 0; l < LANES; l++) begin
                addr_q[l]  <= '0;
                wdata_q[l] <= '0;
            end
        end else if (load) begin
            pending <= lane_valid;
            wen_q   <= lane_wen;
            for (int l = 0; l < LANES; l++) begin
                addr_q[l]  <= lane_addr[l*ADDR_W +: ADDR_W];
                wdata_q[l] <= lane_wdata[l*WORD_W +: WORD_W];
            end
        end else if (serving) begin
            pending <= pending & ~grant;
        end
    end

    // Per-lane read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LANES; l++) begin
                rdata_q[l] <= '0;
            end
        end else if (load) begin
            for (int l = 0; l < LANES; l++) begin
                rdata_q[l] <= '0;
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (grant[l] && !wen_q[l]) begin
                    rdata_q[l] <= bank_rd[lane_bank[l]];
                end
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_rdata[l*WORD_W +: WORD_W] = rdata_q[l];
        end
    end

    // R3: every replay cycle retires at least one pending lane
    p_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && pending != '0) |=> ($countones(pending) < $past($countones(pending))));

    // R5: the lowest pending lane is granted in every serve cycle
    p_lowest_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && pending != '0) |-> (((pending & (~pending + LANES'(1))) & ~grant) == '0));

    // R3: the cycle that clears the mask is followed by done
    p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && last_round) |=> done);
endmodule

// File: tb/test_shared_scratch_banked.sv
module test_shared_scratch_banked;
    localparam int LANES  = 32;
    localparam int ADDR_W = 11;
    localparam int WORDS  = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                   req_valid = 1'b0;
    logic [LANES-1:0]       lane_valid = '0;
    logic [LANES-1:0]       lane_wen = '0;
    logic [LANES*ADDR_W-1:0] lane_addr = '0;
    logic [LANES*32-1:0]    lane_wdata = '0;
    logic ready_a, done_a, ready_b, done_b;
    logic [LANES*32-1:0] rdata_a, rdata_b;

    shared_scratch_banked #(.LANES(32), .BANKS(32), .ROWS(16)) i_shared_scratch_banked (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready_a),
        .lane_valid(lane_valid), .lane_wen(lane_wen), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .done(done_a), .lane_rdata(rdata_a));

    shared_scratch_banked #(.LANES(32), .BANKS(16), .ROWS(32)) i_shared_scratch_banked_b16 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready_b),
        .lane_valid(lane_valid), .lane_wen(lane_wen), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .done(done_b), .lane_rdata(rdata_b));

    int checks = 0;
    int fails  = 0;

    int unsigned model [WORDS];
    int unsigned r_word [LANES];
    logic [31:0] r_wd   [LANES];
    logic [31:0] exp_rd [LANES];
    logic [LANES-1:0] r_val, r_wen;

    task automatic check_val(string rq, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, got, exp);
        end
    endtask

    function automatic int exp_lat(int banks);
        int cnt [32];
        int mx = 0;
        for (int b = 0; b < 32; b++) cnt[b] = 0;
        for (int l = 0; l < LANES; l++) begin
            if (r_val[l]) cnt[r_word[l] % banks]++;
        end
        for (int b = 0; b < 32; b++) if (cnt[b] > mx) mx = cnt[b];
        return mx + 1;
    endfunction

    // Lane-order application: all operations on one word share a bank,
    // so they retire in increasing lane order.
    task automatic compute_model();
        for (int l = 0; l < LANES; l++) begin
            exp_rd[l] = '0;
            if (r_val[l]) begin
                if (r_wen[l]) model[r_word[l]] = r_wd[l];
                else          exp_rd[l] = model[r_word[l]];
            end
        end
    endtask

    task automatic set_inputs();
        for (int l = 0; l < LANES; l++) begin
            lane_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(r_word[l] * 4);
            lane_wdata[l*32 +: 32] = r_wd[l];
        end
        lane_valid = r_val;
        lane_wen   = r_wen;
    endtask

    task automatic cmp_rdata(string rq, logic [LANES*32-1:0] got);
        int bad = -1;
        for (int l = 0; l < LANES; l++) begin
            if (got[l*32 +: 32] !== exp_rd[l] && bad < 0) bad = l;
        end
        if (bad < 0) check_val(rq, "rdata", 0, 0);
        else check_val(rq, $sformatf("rdata lane %0d", bad), got[bad*32 +: 32], exp_rd[bad]);
    endtask

    task automatic run_req(string rq, bit spam);
        int la, lb, n, da, db;
        bit seen_a, seen_b, ready_ok;
        la = exp_lat(32);
        lb = exp_lat(16);
        @(negedge clk);
        set_inputs();
        req_valid = 1'b1;
        compute_model();
        @(posedge clk);
        n = 0; da = 0; db = 0; seen_a = 0; seen_b = 0; ready_ok = 1;
        while (!(seen_a && seen_b) && n < 100) begin
            @(negedge clk);
            n++;
            if (!seen_a) begin
                if (done_a) begin seen_a = 1; da = n; cmp_rdata(rq, rdata_a); end
                else if (ready_a) ready_ok = 0;
            end
            if (!seen_b) begin
                if (done_b) begin seen_b = 1; db = n; cmp_rdata(rq, rdata_b); end
                else if (ready_b) ready_ok = 0;
            end
            if (spam && !seen_a && !seen_b) begin
                // R7: junk stores presented while busy must be ignored
                lane_valid = $urandom;
                lane_wen   = '1;
                for (int l = 0; l < LANES; l++) begin
                    lane_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(($urandom % WORDS) * 4);
                    lane_wdata[l*32 +: 32] = $urandom;
                end
                req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
        end
        check_val(rq, "latency 32 banks", da, la);
        check_val(rq, "latency 16 banks", db, lb);
        check_val("R7", "ready low while busy", ready_ok, 1);
        @(negedge clk);
        cmp_rdata("R8 hold", rdata_a);
    endtask

    task automatic clear_req();
        for (int l = 0; l < LANES; l++) begin
            r_word[l] = 0;
            r_wd[l] = '0;
        end
        r_val = '0;
        r_wen = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int w = 0; w < WORDS; w++) model[w] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 R8: reset state
        check_val("R7", "ready after reset", ready_a, 1);
        check_val("R8", "done after reset", done_a, 0);
        check_val("R8", "rdata after reset", (rdata_a == '0), 1);
        check_val("R7", "ready16 after reset", ready_b, 1);

        // R2: fill memory with distinct-bank stores (1 cycle at 32 banks)
        for (int blk = 0; blk < WORDS / LANES; blk++) begin
            clear_req();
            for (int l = 0; l < LANES; l++) begin
                r_word[l] = blk * LANES + l;
                r_wd[l] = $urandom;
            end
            r_val = '1; r_wen = '1;
            run_req("R2", 0);
        end

        // R1 R2: distinct-bank load of a scattered set
        clear_req();
        for (int l = 0; l < LANES; l++) r_word[l] = ((l * 7) % 32) + 32 * (l % 16);
        r_val = '1;
        run_req("R1 R2", 0);

        // R4 R9: stride 32 -> one bank
        clear_req();
        for (int l = 0; l < LANES; l++) r_word[l] = l * 32 % WORDS + (l >= 16 ? 0 : 0);
        for (int l = 0; l < LANES; l++) r_word[l] = (l % 16) * 32;
        r_val = '1;
        run_req("R4 R9", 0);

        // R9: stride 33 -> all banks
        clear_req();
        for (int l = 0; l < LANES; l++) r_word[l] = (l * 33) % WORDS;
        r_val = '1;
        run_req("R9", 0);

        // R6: all lanes load one word, no merging
        clear_req();
        for (int l = 0; l < LANES; l++) r_word[l] = 77;
        r_val = '1;
        run_req("R6", 0);

        // R5: three writers to one word, highest lane survives
        clear_req();
        r_word[3] = 100; r_word[9] = 100; r_word[20] = 100;
        r_wd[3] = 32'h1111_0003; r_wd[9] = 32'h2222_0009; r_wd[20] = 32'h3333_0014;
        r_val[3] = 1; r_val[9] = 1; r_val[20] = 1;
        r_wen[3] = 1; r_wen[9] = 1; r_wen[20] = 1;
        run_req("R5", 0);
        clear_req();
        r_word[0] = 100; r_val[0] = 1;
        run_req("R5", 0);
        check_val("R5", "surviving writer", rdata_a[31:0], 32'h3333_0014);

        // R10: empty request
        clear_req();
        run_req("R10", 0);

        // R7: busy-time junk ignored, then read back the whole memory
        clear_req();
        for (int l = 0; l < LANES; l++) r_word[l] = (l % 4) * 32 + 5;
        r_val = '1;
        run_req("R7", 1);
        for (int blk = 0; blk < WORDS / LANES; blk++) begin
            clear_req();
            for (int l = 0; l < LANES; l++) r_word[l] = blk * LANES + l;
            r_val = '1;
            run_req("R7", 0);
        end

        // R1 R3 R8: random mixes, sometimes packed into few words
        for (int t = 0; t < 60; t++) begin
            int span;
            span = (t % 3 == 0) ? 8 : WORDS;
            clear_req();
            for (int l = 0; l < LANES; l++) begin
                r_word[l] = (t % 3 == 1) ? (($urandom % 16) * 32 + l % 2) : ($urandom % span);
                r_wd[l] = $urandom;
            end
            r_val = $urandom;
            r_wen = $urandom;
            run_req("R1 R3 R8", (t % 2) == 1);
        end

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule